// File: doc/BRIEF.md
# Dual-Latch Parallel DAC Front End

This block is the digital side of a 16-bit converter with a parallel host bus. A host writes a code into a holding register over a shared bidirectional data bus. It can read that code back over the same bus, which is useful for diagnostics and calibration. A separate load strobe then copies the held code into the register that feeds the converter. This lets several converters be written one after another and then updated together.

An active-low clear forces the converter register to a known code. The read/write line picks which code. With the line at write, the code is all zeros, which is zero output on a unipolar range. With the line at read, only the top bit is set, which is midscale and zero output on a bipolar range.

All control pins and the bus are sampled on a system clock and passed through a synchroniser of `SYNC_STAGES` flops. The latches update one edge after that.

Top module: `dac_bus_front`

## Requirements
- R1: While chipSelN is high, busOe is low, the bus is released to high impedance, and bus activity leaves the holding register unchanged; a later readback shows the old code.
- R2: With chipSelN low and rdNotWr low, the holding register captures the 16-bit bus value.
- R3: With chipSelN low and rdNotWr high, busOe goes high and the holding register is driven onto all 16 bus bits.
- R4: With loadN low and clearN high, the holding register is copied into dacCode whatever chipSelN is. With the default two synchroniser stages, dacCode changes on the third rising edge after the strobe is applied and not before.
- R5: With clearN low and rdNotWr low, dacCode becomes 16'h0000.
- R6: With clearN low and rdNotWr high, dacCode becomes 16'h8000 (bit 15 set, all other bits clear).
- R7: When clearN and loadN are both low in the same cycle, the clear code wins and the holding register is not transferred.
- R8: During reset, dacCode and the holding register are 16'h0000 and busOe is low.
- R9: When neither load nor clear is applied, dacCode holds its value, including across writes to the holding register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| chipSelN | input | 1 | Active-low chip select for bus access |
| rdNotWr | input | 1 | 1 = read back / midscale clear, 0 = write / zero clear |
| loadN | input | 1 | Active-low transfer strobe into the converter register |
| clearN | input | 1 | Active-low clear of the converter register |
| dataBus | inout | 16 | Bidirectional host data bus |
| busOe | output | 1 | High while the block drives dataBus |
| dacCode | output | 16 | Code applied to the converter |

## Verification
Two pairs of functions can land in the same clock cycle. The first pair is clear and load: the bench drops clearN and loadN together, for each level of rdNotWr, after putting a code in the holding register that differs from both clear codes. The converter code must then equal the clear code and never the held code. The second pair is load and bus access: a load is issued during a readback, and also with chip select high. The bench checks that the transfer still happens and that the readback word on the bus is unchanged. A bus model in the bench flags any cycle in which the bench and the block drive the bus together.

// File: rtl/dac_front_pkg.sv
package dac_front_pkg;

  // Decoded one-cycle strobes from control to datapath.
  typedef struct packed {
    logic wrIn;     // capture bus into holding register
    logic rdEn;     // drive holding register onto bus
    logic xfer;     // copy holding register into converter register
    logic clrZero;  // force converter register to zero
    logic clrMid;   // force converter register to midscale
  } strobe_t;

endpackage

// File: rtl/dac_front_ctrl.sv
module dac_front_ctrl
  import dac_front_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chipSelN,
  input  logic              rdNotWr,
  input  logic              loadN,
  input  logic              clearN,
  input  logic [DATA_W-1:0] busIn,
  output strobe_t           strobes,
  output logic [DATA_W-1:0] wrData
);

  typedef struct packed {
    logic              csN;
    logic              rnw;
    logic              ldN;
    logic              clrN;
    logic [DATA_W-1:0] data;
  } samp_t;

  localparam samp_t IDLE_SAMP = '{csN: 1'b1, rnw: 1'b0, ldN: 1'b1, clrN: 1'b1, data: '0};

  samp_t pipe [SYNC_STAGES];
  samp_t rawSamp;
  samp_t lastSamp;

  assign rawSamp = '{csN: chipSelN, rnw: rdNotWr, ldN: loadN, clrN: clearN, data: busIn};

  // Control pins and bus data travel the same stages so they stay aligned.
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe[g] <= IDLE_SAMP;
        else       pipe[g] <= rawSamp;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe[g] <= IDLE_SAMP;
        else       pipe[g] <= pipe[g-1];
      end
    end
  end

  assign lastSamp = pipe[SYNC_STAGES-1];
  assign wrData   = lastSamp.data;

  always_comb begin
    strobes.wrIn    = !lastSamp.csN && !lastSamp.rnw;
    strobes.rdEn    = !lastSamp.csN &&  lastSamp.rnw;
    strobes.clrZero = !lastSamp.clrN && !lastSamp.rnw;
    strobes.clrMid  = !lastSamp.clrN &&  lastSamp.rnw;
    strobes.xfer    = !lastSamp.ldN  &&  lastSamp.clrN;
  end

endmodule

// File: rtl/dac_front_dp.sv
module dac_front_dp
  import dac_front_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] inLatch,
  output logic [DATA_W-1:0] dacCode,
  output logic              busOe
);

  localparam logic [DATA_W-1:0] MIDSCALE = {1'b1, {(DATA_W-1){1'b0}}};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             inLatch <= '0;
    else if (strobes.wrIn) inLatch <= wrData;
  end

  // Clear outranks the transfer strobe.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                dacCode <= '0;
    else if (strobes.clrMid)  dacCode <= MIDSCALE;
    else if (strobes.clrZero) dacCode <= '0;
    else if (strobes.xfer)    dacCode <= inLatch;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busOe <= 1'b0;
    else       busOe <= strobes.rdEn;
  end

endmodule

// File: rtl/dac_bus_front.sv
module dac_bus_front
  import dac_front_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chipSelN,
  input  logic              rdNotWr,
  input  logic              loadN,
  input  logic              clearN,
  inout  wire  [DATA_W-1:0] dataBus,
  output logic              busOe,
  output logic [DATA_W-1:0] dacCode
);

  strobe_t           strobes;
  logic [DATA_W-1:0] wrData;
  logic [DATA_W-1:0] inLatch;

  dac_front_ctrl #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .chipSelN (chipSelN),
    .rdNotWr  (rdNotWr),
    .loadN    (loadN),
    .clearN   (clearN),
    .busIn    (dataBus),
    .strobes  (strobes),
    .wrData   (wrData)
  );

  dac_front_dp #(.DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .wrData  (wrData),
    .inLatch (inLatch),
    .dacCode (dacCode),
    .busOe   (busOe)
  );

  assign dataBus = busOe ? inLatch : {DATA_W{1'bz}};

endmodule

// File: rtl/dac_bus_front_chk.sv
module dac_bus_front_chk
  import dac_front_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input strobe_t           strobes,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] inLatch,
  input logic              busOe,
  input logic [DATA_W-1:0] dacCode
);

  localparam logic [DATA_W-1:0] MID = {1'b1, {(DATA_W-1){1'b0}}};

  assert_hold_unselected_R1: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.wrIn |=> $stable(inLatch));

  assert_capture_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrIn |=> inLatch == $past(wrData));

  assert_readback_enable_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.rdEn |=> busOe);

  assert_release_bus_R1: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.rdEn |=> !busOe);

  assert_transfer_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.xfer && !strobes.clrZero && !strobes.clrMid) |=> dacCode == $past(inLatch));

  assert_clear_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clrZero |=> dacCode == '0);

  assert_clear_mid_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clrMid |=> dacCode == MID);

  assert_clear_exclusive_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.xfer, strobes.clrZero, strobes.clrMid}) || !strobes.xfer);

  assert_code_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.xfer && !strobes.clrZero && !strobes.clrMid) |=> $stable(dacCode));

  always_comb begin
    if (!rstN) begin
      assert_reset_state_R8: assert (dacCode == '0 && inLatch == '0 && !busOe);
    end
  end

endmodule

bind dac_bus_front dac_bus_front_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .strobes (strobes),
  .wrData  (wrData),
  .inLatch (inLatch),
  .busOe   (busOe),
  .dacCode (dacCode)
);

// File: tb/sim_dac_bus_front.sv
`timescale 1ns/1ps
module sim_dac_bus_front;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         chipSelN = 1'b1;
  logic         rdNotWr = 1'b0;
  logic         loadN = 1'b1;
  logic         clearN = 1'b1;
  logic         tbEn = 1'b0;
  logic [W-1:0] tbDrive = '0;
  wire  [W-1:0] dataBus;
  logic         busOe;
  logic [W-1:0] dacCode;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  // Bus model: the bench drives only when enabled.
  assign dataBus = tbEn ? tbDrive : {W{1'bz}};

  dac_bus_front u0 (
    .clk(clk), .rstN(rstN), .chipSelN(chipSelN), .rdNotWr(rdNotWr),
    .loadN(loadN), .clearN(clearN), .dataBus(dataBus),
    .busOe(busOe), .dacCode(dacCode)
  );

  // kind 0: dacCode, 1: readback on bus, 2: bus released
  typedef struct {
    int           kind;
    logic [W-1:0] exp;
    string        req;
  } item_t;

  item_t sbq[$];

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pushExp(input int kind, input logic [W-1:0] exp, input string req);
    item_t it;
    it.kind = kind; it.exp = exp; it.req = req;
    sbq.push_back(it);
  endtask

  // Monitor: pops expectations away from the active edge.
  always @(negedge clk) begin
    if (tbEn || busOe) begin
      checks++;
      if (tbEn && busOe) begin
        failures++;
        $display("FAIL R3 bus contention: busOe=%0b tbEn=%0b expected no overlap", busOe, tbEn);
      end
    end
    while (sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      checks++;
      case (it.kind)
        0: if (dacCode !== it.exp) begin
             failures++;
             $display("FAIL %s dacCode actual=%h expected=%h", it.req, dacCode, it.exp);
           end
        1: if (busOe !== 1'b1 || dataBus !== it.exp) begin
             failures++;
             $display("FAIL %s readback actual=%h oe=%b expected=%h oe=1", it.req, dataBus, busOe, it.exp);
           end
        default: if (busOe !== 1'b0 || dataBus !== {W{1'bz}}) begin
             failures++;
             $display("FAIL %s bus release actual=%h oe=%b expected=zzzz oe=0", it.req, dataBus, busOe);
           end
      endcase
    end
  end

  task automatic writeWord(input logic [W-1:0] v);
    tbEn = 1'b1; tbDrive = v; rdNotWr = 1'b0; chipSelN = 1'b0;
    tick(4);
    chipSelN = 1'b1;
    tick(4);
    tbEn = 1'b0;
    tick(1);
  endtask

  task automatic readCheck(input logic [W-1:0] exp, input string req);
    rdNotWr = 1'b1; chipSelN = 1'b0;
    tick(5);
    pushExp(1, exp, req);
    tick(1);
    chipSelN = 1'b1;
    tick(5);
    rdNotWr = 1'b0;
    tick(1);
  endtask

  task automatic pulseLoad();
    loadN = 1'b0; tick(4);
    loadN = 1'b1; tick(4);
  endtask

  task automatic pulseClear(input logic rnw);
    rdNotWr = rnw; clearN = 1'b0; tick(4);
    clearN = 1'b1; tick(4);
    rdNotWr = 1'b0; tick(1);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired before end of sequence");
    finishRun();
  end

  initial begin
    // R8: reset state
    tick(3);
    pushExp(0, 16'h0000, "R8");
    pushExp(2, 16'h0000, "R8");
    tick(1);
    rstN = 1'b1;
    tick(2);
    readCheck(16'h0000, "R8");

    // R2 / R3 / R9: write, read back, code unchanged by writes
    writeWord(16'hA5C3);
    readCheck(16'hA5C3, "R3");
    pushExp(0, 16'h0000, "R9");
    tick(1);

    // R1: bus activity with chip select high
    tbEn = 1'b1; tbDrive = 16'h1234; chipSelN = 1'b1; rdNotWr = 1'b0;
    tick(6);
    tbEn = 1'b0;
    tick(1);
    pushExp(2, 16'h0000, "R1");
    tick(1);
    readCheck(16'hA5C3, "R1");

    // R4: load with chip select high, latency check
    loadN = 1'b0;
    tick(2);
    pushExp(0, 16'h0000, "R4");
    tick(1);
    pushExp(0, 16'hA5C3, "R4");
    tick(2);
    loadN = 1'b1;
    tick(4);

    // R2 again with different pattern; R9 hold
    writeWord(16'h5A3C);
    pushExp(0, 16'hA5C3, "R9");
    readCheck(16'h5A3C, "R2");

    // R5 / R6: clear codes
    pulseClear(1'b0);
    pushExp(0, 16'h0000, "R5");
    tick(1);
    pulseClear(1'b1);
    pushExp(0, 16'h8000, "R6");
    tick(1);

    // R4: load during a readback
    writeWord(16'h7FFF);
    rdNotWr = 1'b1; chipSelN = 1'b0; loadN = 1'b0;
    tick(5);
    pushExp(0, 16'h7FFF, "R4");
    pushExp(1, 16'h7FFF, "R3");
    tick(1);
    loadN = 1'b1; chipSelN = 1'b1;
    tick(5);
    rdNotWr = 1'b0;
    tick(1);

    // R7: clear and load together, midscale
    pulseClear(1'b0);
    rdNotWr = 1'b1; clearN = 1'b0; loadN = 1'b0;
    tick(5);
    pushExp(0, 16'h8000, "R7");
    tick(1);
    clearN = 1'b1; loadN = 1'b1;
    tick(5);
    pushExp(0, 16'h8000, "R7");
    rdNotWr = 1'b0;
    tick(1);

    // R7: clear and load together, zero
    writeWord(16'hFFFF);
    clearN = 1'b0; loadN = 1'b0; rdNotWr = 1'b0;
    tick(5);
    pushExp(0, 16'h0000, "R7");
    tick(1);
    clearN = 1'b1; loadN = 1'b1;
    tick(5);
    pushExp(0, 16'h0000, "R7");
    tick(1);

    // R4: plain load of FFFF
    pulseLoad();
    pushExp(0, 16'hFFFF, "R4");
    tick(1);
    pushExp(2, 16'h0000, "R1");
    tick(2);

    finishRun();
  end

endmodule